// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to `NUM_SRC` interrupt inputs into one request line for a processor. Each input is captured into a sticky status bit. A parameter mask selects, per source, whether the input is rising-edge sensitive or level sensitive. Software masks the status bits through an enable register, and the masked result forms the pending set. The request line is raised when any source is pending and both bits of a two-bit master enable are set.

Software reaches the block through a plain 32-bit register bus with a word index. It can replace the whole enable mask, or it can set or clear single enable bits without a read-modify-write. It acknowledges serviced sources by writing a mask. It reads the number of the lowest-numbered pending source from a vector register. While the hardware-enable bit of the master register is still clear, software may write the status register directly to raise test interrupts.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset the enable, status and master registers read 0, the vector register reads 32'hFFFF_FFFF, and `irqReq` is low.
- R2: A write to the set-enable register (word index 4) ORs the written mask into the enable register (word index 2). Every other enable bit keeps its value.
- R3: A write to the clear-enable register (word index 5) clears the bits that are 1 in the written mask. Every other enable bit keeps its value.
- R4: The pending register (word index 1) reads status AND enable. Bit n of every per-source register belongs to input `irqIn[n]`.
- R5: A source marked as edge-type in `EDGE_MASK` (by default bits 0 to 15) sets its status bit (word index 0) on a 0-to-1 change of its input. The bit stays set after the input falls. A level-type source (by default bits 16 to 31) sets its status bit in every cycle that its input is high.
- R6: Writing a mask to the acknowledge register (word index 3) clears those status bits. If a new rising edge arrives in the same cycle, or a level input is still high, the bit stays set.
- R7: The vector register (word index 6) returns the index of the lowest-numbered pending source. It returns 32'hFFFF_FFFF when nothing is pending.
- R8: `irqReq` is high exactly when some pending bit is set and the master register (word index 7) holds 2'b11. Either master bit at 0 holds `irqReq` low.
- R9: A write to the status register replaces its contents while master bit 1 is 0. Once master bit 1 is 1, such writes are ignored.
- R10: The acknowledge, set-enable and clear-enable registers read as 0. The master register reads its two bits zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Word index (byte offset / 4) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from `busAddr` |
| irqIn | input | NUM_SRC | Interrupt source inputs |
| irqReq | output | 1 | Interrupt request to the processor |

## Verification
The assertions assume that the bus carries at most one write per cycle, so set-enable, clear-enable, acknowledge and status writes never coincide. They also assume that `irqIn` is synchronous to `clk`. The bench drives every bus and input change on the falling edge and holds each write for exactly one rising edge. It samples the combinational read data a short delay after driving the address. The same-cycle case drives an input rise and an acknowledge write together, so that both land on one rising edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [2:0] {
    REG_STATUS  = 3'd0,
    REG_PENDING = 3'd1,
    REG_ENABLE  = 3'd2,
    REG_ACK     = 3'd3,
    REG_SETEN   = 3'd4,
    REG_CLREN   = 3'd5,
    REG_VECTOR  = 3'd6,
    REG_MASTER  = 3'd7
  } regSel_e;

  typedef struct packed {
    logic    wrStatus;
    logic    wrEnable;
    logic    wrAck;
    logic    wrSetEn;
    logic    wrClrEn;
    logic    wrMaster;
    regSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic       busSel,
  input  logic       busWe,
  input  logic [2:0] busAddr,
  output strobe_t    strb
);
  regSel_e sel;
  logic    wr;

  always_comb begin
    sel           = regSel_e'(busAddr);
    wr            = busSel && busWe;
    strb          = '0;
    strb.rdSel    = sel;
    strb.wrStatus = wr && (sel == REG_STATUS);
    strb.wrEnable = wr && (sel == REG_ENABLE);
    strb.wrAck    = wr && (sel == REG_ACK);
    strb.wrSetEn  = wr && (sel == REG_SETEN);
    strb.wrClrEn  = wr && (sel == REG_CLREN);
    strb.wrMaster = wr && (sel == REG_MASTER);
  end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  // Scan from the top down so the lowest-numbered request is assigned last and wins.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter int                 DATA_W    = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h0000_FFFF,
  localparam int                IDX_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  rdata,
  output logic               irqReq
);
  logic [NUM_SRC-1:0] prevIn, rise, setMask;
  logic [NUM_SRC-1:0] statusQ, statusD, enableQ, pending;
  logic [NUM_SRC-1:0] wMask;
  logic [1:0]         masterQ;
  logic               vecFound;
  logic [IDX_W-1:0]   vecIdx;

  assign wMask   = wdata[NUM_SRC-1:0];
  assign rise    = irqIn & ~prevIn;
  assign setMask = (rise & EDGE_MASK) | (irqIn & ~EDGE_MASK);
  assign pending = statusQ & enableQ;

  always_comb begin
    statusD = statusQ;
    if (strb.wrStatus && !masterQ[1]) statusD = wMask;
    if (strb.wrAck) statusD = statusD & ~wMask;
    statusD = statusD | setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevIn  <= '0;
      statusQ <= '0;
      enableQ <= '0;
      masterQ <= '0;
    end else begin
      prevIn  <= irqIn;
      statusQ <= statusD;
      if (strb.wrEnable)     enableQ <= wMask;
      else if (strb.wrSetEn) enableQ <= enableQ | wMask;
      else if (strb.wrClrEn) enableQ <= enableQ & ~wMask;
      if (strb.wrMaster) masterQ <= wdata[1:0];
    end
  end

  irqc_prio #(.NUM_SRC(NUM_SRC)) uPrio (
    .req  (pending),
    .found(vecFound),
    .idx  (vecIdx)
  );

  assign irqReq = (|pending) && (masterQ == 2'b11);

  always_comb begin
    rdata = '0;
    unique case (strb.rdSel)
      REG_STATUS:  rdata[NUM_SRC-1:0] = statusQ;
      REG_PENDING: rdata[NUM_SRC-1:0] = pending;
      REG_ENABLE:  rdata[NUM_SRC-1:0] = enableQ;
      REG_VECTOR:  rdata = vecFound ? DATA_W'(vecIdx) : '1;
      REG_MASTER:  rdata[1:0] = masterQ;
      default:     rdata = '0;
    endcase
  end

  assert_seten_or_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetEn |=> ((enableQ & $past(wMask)) == $past(wMask)));
  assert_seten_keep_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSetEn |=> ((enableQ & ~$past(wMask)) == ($past(enableQ) & ~$past(wMask))));
  assert_clren_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClrEn |=> ((enableQ & $past(wMask)) == '0));
  assert_edge_beats_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrAck |=> ((statusQ & $past(rise & EDGE_MASK)) == $past(rise & EDGE_MASK)));
  assert_status_locked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStatus && masterQ[1]) |=> (($past(statusQ) & ~statusQ) == '0));
  assert_vector_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    vecFound |-> pending[vecIdx]);
  assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (masterQ == 2'b11));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqc_pkg::*;
#(
  parameter int                 NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = 32'h0000_FFFF
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWe,
  input  logic [2:0]         busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic               irqReq
);
  strobe_t strb;

  irqc_ctrl uCtrl (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .strb   (strb)
  );

  irqc_datapath #(
    .NUM_SRC  (NUM_SRC),
    .DATA_W   (32),
    .EDGE_MASK(EDGE_MASK)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .wdata (busWdata),
    .irqIn (irqIn),
    .rdata (busRdata),
    .irqReq(irqReq)
  );
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/100ps
module sim_irq_vector_ctrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic        busSel = 0, busWe = 0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] irqIn = '0;
  logic        irqReq;
  int          nRun = 0, nFail = 0;
  bit          done = 0;

  localparam logic [2:0] A_STAT = 0, A_PEND = 1, A_EN = 2, A_ACK = 3,
                         A_SET = 4, A_CLR = 5, A_VEC = 6, A_MST = 7;

  always #2.5 clk = ~clk;

  irq_vector_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn), .irqReq(irqReq)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWe = 1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 0; busWe = 0;
  endtask

  task automatic rdChk(string req, logic [2:0] a, logic [31:0] exp);
    @(negedge clk);
    busSel = 1; busWe = 0; busAddr = a;
    #1;
    check(req, busRdata, exp);
    busSel = 0;
  endtask

  task automatic pulse(int n);
    @(negedge clk);
    irqIn[n] = 1;
    @(negedge clk);
    irqIn[n] = 0;
  endtask

  task automatic reqChk(string req, logic exp);
    @(negedge clk);
    #1;
    check(req, {31'd0, irqReq}, {31'd0, exp});
  endtask

  task automatic testReset();
    rdChk("R1 enable", A_EN, 0);
    rdChk("R1 status", A_STAT, 0);
    rdChk("R1 master", A_MST, 0);
    rdChk("R1 vector", A_VEC, 32'hFFFF_FFFF);
    reqChk("R1 irqReq", 0);
  endtask

  task automatic testEnable();
    wr(A_SET, 32'h5);
    rdChk("R2 set first", A_EN, 32'h5);
    wr(A_SET, 32'h30);
    rdChk("R2 set keeps", A_EN, 32'h35);
    wr(A_CLR, 32'h4);
    rdChk("R3 clear one", A_EN, 32'h31);
    rdChk("R10 seten reads 0", A_SET, 0);
    rdChk("R10 clren reads 0", A_CLR, 0);
    rdChk("R10 ack reads 0", A_ACK, 0);
  endtask

  task automatic testCapture();
    pulse(3);
    rdChk("R5 edge sticky", A_STAT, 32'h8);
    @(negedge clk); irqIn[3] = 1;
    wr(A_ACK, 32'h8);
    rdChk("R5 edge no recapture while high", A_STAT, 0);
    @(negedge clk); irqIn[3] = 0;
    @(negedge clk); irqIn[20] = 1;
    rdChk("R5 level set", A_STAT, 32'h0010_0000);
    wr(A_ACK, 32'h0010_0000);
    rdChk("R6 level held while high", A_STAT, 32'h0010_0000);
    @(negedge clk); irqIn[20] = 0;
    wr(A_ACK, 32'hFFFF_FFFF);
    rdChk("R6 ack all", A_STAT, 0);
  endtask

  task automatic testAckRace();
    pulse(4);
    rdChk("R6 pre", A_STAT, 32'h10);
    @(negedge clk);
    irqIn[4] = 1; busSel = 1; busWe = 1; busAddr = A_ACK; busWdata = 32'h10;
    @(negedge clk);
    busSel = 0; busWe = 0;
    rdChk("R6 edge with ack keeps", A_STAT, 32'h10);
    wr(A_ACK, 32'h10);
    rdChk("R6 ack clears", A_STAT, 0);
    @(negedge clk); irqIn[4] = 0;
  endtask

  task automatic testPending();
    wr(A_CLR, 32'hFFFF_FFFF);
    wr(A_SET, 32'h0010_0008);
    pulse(3);
    pulse(5);
    @(negedge clk); irqIn[20] = 1;
    rdChk("R4 status", A_STAT, 32'h0010_0028);
    rdChk("R4 pending", A_PEND, 32'h0010_0008);
    rdChk("R7 vector lowest", A_VEC, 32'd3);
    @(negedge clk); irqIn[20] = 0;
    wr(A_ACK, 32'hFFFF_FFFF);
    wr(A_CLR, 32'hFFFF_FFFF);
  endtask

  task automatic testGating();
    wr(A_STAT, 32'h300);
    wr(A_SET, 32'h200);
    rdChk("R7 vector single", A_VEC, 32'd9);
    wr(A_MST, 32'h1);
    reqChk("R8 bit1 clear", 0);
    wr(A_MST, 32'h3);
    reqChk("R8 both set", 1);
    rdChk("R10 master read", A_MST, 32'h3);
    wr(A_MST, 32'h2);
    reqChk("R8 bit0 clear", 0);
    wr(A_SET, 32'h100);
    rdChk("R7 lower wins", A_VEC, 32'd8);
    wr(A_ACK, 32'h100);
    rdChk("R7 after ack", A_VEC, 32'd9);
    wr(A_ACK, 32'hFFFF_FFFF);
    rdChk("R7 none", A_VEC, 32'hFFFF_FFFF);
  endtask

  task automatic testStatusWrite();
    wr(A_MST, 32'h0);
    wr(A_STAT, 32'h80);
    rdChk("R9 write allowed", A_STAT, 32'h80);
    wr(A_MST, 32'h2);
    wr(A_STAT, 32'h0);
    rdChk("R9 write ignored", A_STAT, 32'h80);
    wr(A_STAT, 32'h1);
    rdChk("R9 set ignored", A_STAT, 32'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testEnable();
    testCapture();
    testAckRace();
    testPending();
    testGating();
    testStatusWrite();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule